// File: doc/BRIEF.md
# Serial EEPROM Slave Front End

This block is the two-wire serial front end of a byte-addressed nonvolatile memory that answers as a bus slave. It runs on a system clock at least eight times the serial clock rate. It brings the incoming SCL and SDA lines into that clock domain through a two-flop synchroniser, finds START and STOP conditions, and shifts bytes in most significant bit first. It decodes a select byte that carries the direction and the top address bits, and it keeps the memory address counter. Toward the bus it only pulls the data line low: `sda_oe` high means drive 0, and low means release.

Toward the storage array the block issues one single-cycle write request per received data byte. It presents its address counter as the read address and expects the read byte back combinationally. Write requests advance the counter inside a 16-byte page. Read transfers advance it over the whole array and wrap from the top address to 0.

The controller is one state machine with nine states. IDLE waits for START. SELECT receives the select byte. SEL_ACK acknowledges it. ADDR receives the low address byte and ADDR_ACK acknowledges it. WDATA receives a data byte and WDATA_ACK acknowledges it. RDATA sends a byte and MACK samples the master's acknowledge. The transitions are as follows:
- START from any state goes to SELECT, and STOP from any state goes to IDLE.
- SELECT goes to SEL_ACK on a matching device code and to IDLE otherwise.
- SEL_ACK goes to RDATA for a read select and to ADDR for a write select.
- ADDR goes to ADDR_ACK, ADDR_ACK goes to WDATA, WDATA goes to WDATA_ACK, and WDATA_ACK goes back to WDATA.
- RDATA goes to MACK. MACK goes to RDATA on an acknowledge and to IDLE on a missing acknowledge.

Top module: `nvm_serial_slave`

## Requirements
- R1: After reset `sda_oe` and `wr_en` are 0 and the address counter `rd_addr` is 0.
- R2: A select byte whose bits 7..4 differ from 1010 gets no acknowledge. The slave then drives nothing until the next START.
- R3: A select byte with bits 7..4 = 1010 and bit 0 = 0 is acknowledged on the ninth SCL pulse. Its bits 3..1 load address bits 10..8 of the counter.
- R4: The byte after an acknowledged write select is acknowledged and loads counter bits 7..0.
- R5: Each later byte of a write transfer is acknowledged. It causes exactly one `wr_en` pulse of one clock cycle, carrying the counter value as `wr_addr` and the byte as `wr_data`.
- R6: After each written byte, counter bits 3..0 increment and wrap within the page, and the bits above them stay unchanged.
- R7: A select byte with bit 0 = 1 is acknowledged, leaves the counter unchanged whatever its bits 3..1 hold, and reads from the current counter value.
- R8: A repeated START after the address byte abandons the write without any `wr_en` pulse. A following read select then reads the loaded address.
- R9: Read bytes go out MSB first. `sda_oe` changes only while SCL is low, and the counter advances by one for every byte sent.
- R10: The slave keeps sending bytes while the master acknowledges, and the counter wraps from the highest address (2047) to 0.
- R11: A missing master acknowledge ends the read. The slave releases SDA and ignores further SCL pulses until a START.
- R12: A STOP in any state returns the slave to IDLE with SDA released and the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_en | output | 1 | Single-cycle byte write request |
| wr_addr | output | ADDR_W | Address of the write request |
| wr_data | output | 8 | Byte of the write request |
| rd_addr | output | ADDR_W | Current address counter, used as read address |
| rd_data | input | 8 | Array byte at `rd_addr`, combinational |

## Verification
The assertions check four properties on every cycle: every write pulse lasts one cycle and falls inside the data acknowledge phase, the data line never changes while SCL is high, and STOP releases the line. Inside the counter they also check the page increment and the wrap from the top address to 0. The bench's bus transfers alone can show the others. These are device-code rejection, address loading from both bytes, random and current address reads, sequential reads across the top address, the NACK ending a read, and the effect of a STOP in the middle of a byte. The bench checks them by reading bytes back through the bus against a model of the array.

// File: rtl/nvm_slave_pkg.sv
package nvm_slave_pkg;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SELECT,
        ST_SEL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_MACK
    } slv_state_t;
endpackage

// File: rtl/nvm_bus_sync.sv
module nvm_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_chain;
    logic [SYNC_STAGES-1:0] sda_chain;
    logic                   scl_q;
    logic                   sda_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= scl_i;
                    sda_chain <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
                    sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_s     = scl_chain[SYNC_STAGES-1];
    assign sda_s     = sda_chain[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/nvm_addr_ctr.sv
module nvm_addr_ctr #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_hi,
    input  logic [ADDR_W-9:0] hi_val,
    input  logic              load_lo,
    input  logic [7:0]        lo_val,
    input  logic              inc_page,
    input  logic              inc_full,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [PAGE_W-1:0] PAGE_ONE = {{(PAGE_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] FULL_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load_hi) begin
            addr[ADDR_W-1:8] <= hi_val;
        end else if (load_lo) begin
            addr[7:0] <= lo_val;
        end else if (inc_page) begin
            addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + PAGE_ONE;
        end else if (inc_full) begin
            addr <= addr + FULL_ONE;
        end
    end

    // R6: a written byte advances only the in-page bits
    a_r6_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inc_page) |->
            (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])) &&
            (addr[PAGE_W-1:0] == $past(addr[PAGE_W-1:0]) + PAGE_ONE));

    // R10: a sent byte at the top address wraps the counter to zero
    a_r10_top_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inc_full) && ($past(addr) == {ADDR_W{1'b1}})) |-> (addr == '0));
endmodule

// File: rtl/nvm_serial_slave.sv
module nvm_serial_slave
    import nvm_slave_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data
);
    localparam int HI_W = ADDR_W - 8;

    slv_state_t state, nxt;
    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic [7:0] txreg;
    logic       mack;
    logic       byte_full, dev_hit, rd_sel;
    logic       load_hi, load_lo, inc_page, inc_full;

    nvm_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign byte_full = (bit_cnt == 4'd8);
    assign dev_hit   = (shreg[7:4] == DEV_CODE);
    assign rd_sel    = shreg[0];

    assign load_hi  = (state == ST_SELECT) && scl_fall && byte_full && dev_hit && !rd_sel;
    assign load_lo  = (state == ST_ADDR) && scl_fall && byte_full;
    assign inc_page = (state == ST_WDATA) && scl_fall && byte_full;
    assign inc_full = ((state == ST_SEL_ACK) && scl_fall && rd_sel) ||
                      ((state == ST_MACK) && scl_fall && mack);

    nvm_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .load_hi(load_hi), .hi_val(shreg[HI_W:1]),
        .load_lo(load_lo), .lo_val(shreg),
        .inc_page(inc_page), .inc_full(inc_full),
        .addr(rd_addr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_SELECT;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_SELECT:    if (scl_fall && byte_full) nxt = dev_hit ? ST_SEL_ACK : ST_IDLE;
                ST_SEL_ACK:   if (scl_fall) nxt = rd_sel ? ST_RDATA : ST_ADDR;
                ST_ADDR:      if (scl_fall && byte_full) nxt = ST_ADDR_ACK;
                ST_ADDR_ACK:  if (scl_fall) nxt = ST_WDATA;
                ST_WDATA:     if (scl_fall && byte_full) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nxt = ST_WDATA;
                ST_RDATA:     if (scl_fall && bit_cnt == 4'd7) nxt = ST_MACK;
                ST_MACK:      if (scl_fall) nxt = mack ? ST_RDATA : ST_IDLE;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // datapath: shifters, bit counter, write request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            txreg   <= '0;
            mack    <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
            end else begin
                unique case (state)
                    ST_SELECT, ST_ADDR, ST_WDATA: begin
                        if (scl_rise && !byte_full) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (state == ST_WDATA && scl_fall && byte_full) begin
                            wr_en   <= 1'b1;
                            wr_addr <= rd_addr;
                            wr_data <= shreg;
                        end
                    end
                    ST_SEL_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rd_sel) txreg <= rd_data;
                        end
                    end
                    ST_ADDR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) bit_cnt <= '0;
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            txreg   <= {txreg[6:0], 1'b1};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) mack <= ~sda_s;
                        if (scl_fall && mack) begin
                            txreg   <= rd_data;
                            bit_cnt <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_SEL_ACK, ST_ADDR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~txreg[7];
            default:                               sda_oe = 1'b0;
        endcase
    end

    // R5: a write request lasts one cycle
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R5: a write request only appears while the data byte is acknowledged
    a_r5_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state == ST_WDATA_ACK));

    // R9: the slave never moves SDA while SCL is high
    a_r9_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(stop_det) && !$past(start_det)) |-> $stable(sda_oe));

    // R12: STOP releases the data line
    a_r12_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
endmodule

// File: tb/nvm_serial_slave_test.sv
module nvm_serial_slave_test;
    localparam int ADDR_W = 11;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scl_m = 1'b1;
    logic              m_low = 1'b0;
    logic              sda_line;
    logic              sda_oe;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;

    logic [7:0] mem     [DEPTH];
    logic [7:0] exp_mem [DEPTH];
    int         wr_cnt = 0;
    int         log_addr [64];
    int         log_data [64];
    int         checks = 0;
    int         errors = 0;

    always #10 clk = ~clk;

    assign sda_line = ~(m_low | sda_oe);
    assign rd_data  = mem[rd_addr];

    nvm_serial_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
            if (wr_cnt < 64) begin
                log_addr[wr_cnt] = int'(wr_addr);
                log_data[wr_cnt] = int'(wr_data);
            end
            wr_cnt = wr_cnt + 1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic bus_start();
        m_low = 1'b0; tick(8);
        scl_m = 1'b1; tick(16);
        m_low = 1'b1; tick(16);
        scl_m = 1'b0; tick(8);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(8);
        scl_m = 1'b1; tick(16);
        m_low = 1'b0; tick(16);
    endtask

    task automatic send_bit(input bit b);
        m_low = ~b; tick(8);
        scl_m = 1'b1; tick(16);
        scl_m = 1'b0; tick(8);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_low = 1'b0; tick(8);
        scl_m = 1'b1; tick(8);
        acked = ~sda_line; tick(8);
        scl_m = 1'b0; tick(8);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b, output bit glitch);
        logic s1;
        glitch = 1'b0;
        m_low  = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(8);
            scl_m = 1'b1; tick(4);
            s1 = sda_line; tick(8);
            if (sda_line !== s1) glitch = 1'b1;
            b[i] = s1; tick(4);
            scl_m = 1'b0; tick(8);
        end
        send_bit(~give_ack);
        m_low = 1'b0;
    endtask

    function automatic logic [7:0] sel_byte(input int hi, input bit rd);
        return {4'b1010, 3'(hi), rd};
    endfunction

    task automatic set_addr(input int addr, input string tag);
        bit a;
        bus_start();
        send_byte(sel_byte(addr >> 8, 1'b0), a);
        chk(a, {tag, " select ack"}, int'(a), 1);
        send_byte(8'(addr), a);
        chk(a, {tag, " address ack"}, int'(a), 1);
    endtask

    task automatic write_txn(input int addr, input int n, input int first, input string tag);
        bit a;
        set_addr(addr, tag);
        for (int i = 0; i < n; i++) begin
            send_byte(8'(first + i), a);
            chk(a, {tag, " data ack"}, int'(a), 1);
            exp_mem[(addr & ~15) | ((addr + i) & 15)] = 8'(first + i);
        end
        bus_stop();
    endtask

    task automatic read_seq(input int from_addr, input int n, input string tag);
        logic [7:0] b;
        bit         g;
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b, g);
            chk(b == exp_mem[(from_addr + i) % DEPTH], tag, int'(b),
                int'(exp_mem[(from_addr + i) % DEPTH]));
            chk(!g, "R9 data stable while SCL high", int'(g), 0);
        end
        bus_stop();
    endtask

    task automatic random_read(input int addr, input int n, input string tag);
        bit a;
        set_addr(addr, tag);
        bus_start();
        send_byte(sel_byte(0, 1'b1), a);
        chk(a, {tag, " read select ack"}, int'(a), 1);
        read_seq(addr, n, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit a;
        int n0;
        logic [7:0] b;
        bit g;
        int bad;
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]     = 8'((i * 7 + 3) ^ (i >> 8));
            exp_mem[i] = 8'((i * 7 + 3) ^ (i >> 8));
        end
        tick(5);
        // R1 reset state
        chk(sda_oe == 1'b0, "R1 sda_oe after reset", int'(sda_oe), 0);
        chk(wr_en == 1'b0, "R1 wr_en after reset", int'(wr_en), 0);
        chk(rd_addr == '0, "R1 counter after reset", int'(rd_addr), 0);
        rst_n = 1'b1;
        tick(10);

        // R2 foreign device code
        bus_start();
        send_byte(8'hB0, a);
        chk(!a, "R2 foreign select not acked", int'(a), 0);
        send_byte(8'h00, a);
        chk(!a, "R2 silent until START", int'(a), 0);
        bus_stop();
        chk(wr_cnt == 0, "R2 no write", wr_cnt, 0);

        // R3 R4 R5 byte write
        write_txn(12'h5A3, 1, 8'h3C, "R3 R4 byte write");
        chk(wr_cnt == 1, "R5 one pulse", wr_cnt, 1);
        chk(log_addr[0] == 12'h5A3, "R5 wr_addr", log_addr[0], 12'h5A3);
        chk(log_data[0] == 8'h3C, "R5 wr_data", log_data[0], 8'h3C);

        // R6 page write wrapping in page
        n0 = wr_cnt;
        write_txn(12'h12E, 4, 8'h90, "R6 page write");
        for (int i = 0; i < 4; i++) begin
            chk(log_addr[n0 + i] == ((12'h12E & ~15) | ((12'h12E + i) & 15)),
                "R6 page address", log_addr[n0 + i], (12'h12E & ~15) | ((12'h12E + i) & 15));
        end

        // R8 random read, no write issued
        n0 = wr_cnt;
        random_read(12'h5A3, 1, "R8 random read");
        chk(wr_cnt == n0, "R8 abandoned write", wr_cnt, n0);
        random_read(12'h120, 2, "R6 R8 page wrap readback");

        // R7 current address read with don't-care bits set
        random_read(12'h5A3, 1, "R8 position");
        bus_start();
        send_byte(8'hAF, a);
        chk(a, "R7 read select ack", int'(a), 1);
        read_seq(12'h5A4, 1, "R7 current address read");
        bus_start();
        send_byte(8'hA3, a);
        read_seq(12'h5A5, 1, "R9 counter advanced per byte");

        // R10 sequential read across top
        random_read(12'h7FE, 4, "R10 sequential wrap");

        // R11 no activity after NACK until START
        bad = 0;
        for (int i = 0; i < 9; i++) begin
            m_low = 1'b0; tick(8);
            scl_m = 1'b1; tick(8);
            if (sda_oe) bad++;
            tick(8);
            scl_m = 1'b0; tick(8);
            if (sda_oe) bad++;
        end
        chk(bad == 0, "R11 released after NACK", bad, 0);
        bus_stop();

        // R12 STOP mid address byte
        bus_start();
        send_byte(sel_byte(3, 1'b0), a);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        chk(sda_oe == 1'b0, "R12 released after STOP", int'(sda_oe), 0);
        bus_start();
        send_byte(8'hA1, a);
        recv_byte(1'b0, b, g);
        bus_stop();
        chk(b == exp_mem[12'h302], "R12 counter kept low byte", int'(b), int'(exp_mem[12'h302]));

        // R3 sweep over all upper address values
        for (int h = 0; h < 8; h++) begin
            write_txn((h << 8) | (h * 16 + 5), 1, 8'h80 ^ (h * 9), "R3 sweep write");
            random_read((h << 8) | (h * 16 + 5), 1, "R3 sweep readback");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule